// File: doc/BRIEF.md
# Programmable Gain Ramp Envelope

This block holds a 6-bit gain and moves it one step up or down at a programmable rate. One copy drives a channel's loudness and a second copy drives the depth of its pitch sweep. Both share a global 8-bit rate multiplier and a channel-wide envelope-halt input. The host writes one configuration byte, and reads back the live gain in a fixed byte layout.

The configuration byte has three fields. Bit 7 is the off flag: 0 lets the ramp run and 1 stops it. Bit 6 is the slope: 0 counts down and 1 counts up. Bits 5:0 are the value field. Every write takes the value field as the step-rate setting. The gain is loaded from the value field only when the off flag is written as 1. A step fires once every 8 × multiplier × (rate setting + 1) clock cycles. Upward steps stop at 32. A direct load can still set any value up to 63. A second output gives the gain clamped to 32 for the consumer.

The configuration write, the halts and the multiplier are plain control pins with no handshake. A write takes effect at the clock edge that samples `cfg_wr` high.

Top module: `gain_ramp`

## Requirements
- R1: On a write, bits 5:0 of `cfg_data` become the rate setting, bit 6 becomes the slope and bit 7 becomes the off flag. The gain is loaded from bits 5:0 only when bit 7 is 1. A write with bit 7 equal to 0 leaves the gain as it was.
- R2: Every write restarts the step timer. The next step comes a full period after the edge that accepted the write.
- R3: While the ramp runs, steps occur every 8 × `glob_rate` × (rate setting + 1) cycles.
- R4: With `glob_rate` equal to 0 the gain never steps.
- R5: An upward step adds 1 only when the gain is below 32. A gain loaded above 32 is not stepped up.
- R6: A downward step subtracts 1 only when the gain is above 0.
- R7: With the off flag at 1 the gain never steps.
- R8: While `env_halt` is 1 the gain does not step and the timer is held at zero. The first step after release comes a full period after the last halted edge.
- R9: While `wave_halt` is 1 the gain does not step and the timer keeps its count. Counting resumes from that count after release.
- R10: `gain_clamped` equals min(gain, 32). `rd_data` equals {2'b01, gain}.
- R11: After reset the gain is 0, the rate setting is 0, the off flag is 1 and the timer is 0. So `rd_data` reads 8'h40 and no step occurs until a write clears the off flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock (one CPU clock per cycle) |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration byte write strobe |
| cfg_data | input | 8 | Configuration byte: off flag, slope, value |
| glob_rate | input | 8 | Shared rate multiplier; 0 stops stepping |
| env_halt | input | 1 | Channel envelope halt; freezes the gain and clears the timer |
| wave_halt | input | 1 | Waveform halt; freezes the gain and holds the timer |
| gain_raw | output | 6 | Current gain, 0 to 63 |
| gain_clamped | output | 6 | Gain limited to 32 |
| rd_data | output | 8 | Readback byte {2'b01, gain} |

## Verification
A wrong timer count shows only at the ports, as a step that arrives early or late. The bench therefore measures the exact number of cycles from a write, a halt release or a previous step to the next gain change. It sweeps several multipliers and rate settings, and one off-by-one error moves every measured period. A wrong gain update rule shows within one period: the gain climbs past 32, wraps below 0, or moves while the ramp is off. The bench checks the clamp and the readback for all 64 load values, straight after each load.

// File: rtl/gain_ramp_pkg.sv
package gain_ramp_pkg;
  localparam int GAIN_BITS  = 6;
  localparam int RATE_BITS  = 8;
  localparam int PRE_SCALE  = 8;
  localparam int GAIN_LIMIT = 32;

  typedef struct packed {
    logic                 off;
    logic                 rise;
    logic [GAIN_BITS-1:0] val;
  } ramp_cfg_t;
endpackage

// File: rtl/gain_ramp_timer.sv
module gain_ramp_timer #(
  parameter int GAIN_W   = 6,
  parameter int RATE_W   = 8,
  parameter int PRESCALE = 8,
  localparam int MAX_PERIOD = PRESCALE * ((1 << RATE_W) - 1) * (1 << GAIN_W),
  localparam int TIMER_W    = $clog2(MAX_PERIOD + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              run,
  input  logic [RATE_W-1:0] glob_rate,
  input  logic [GAIN_W-1:0] rate_set,
  output logic              tick
);
  logic [TIMER_W-1:0] cnt_q;
  logic [TIMER_W-1:0] period;

  always_comb begin
    period = TIMER_W'(PRESCALE) * TIMER_W'(glob_rate) * (TIMER_W'(rate_set) + TIMER_W'(1));
  end

  // The ">=" compare avoids a stall when the multiplier shrinks mid-count.
  assign tick = run && !clr && (cnt_q >= period - TIMER_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (run)    cnt_q <= tick ? '0 : cnt_q + TIMER_W'(1);
  end

  assert_tick_needs_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (run && glob_rate != '0));
  assert_clear_restarts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/gain_ramp_level.sv
module gain_ramp_level #(
  parameter int GAIN_W = 6,
  parameter int CAP    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [GAIN_W-1:0] load_val,
  input  logic              tick,
  input  logic              rise,
  output logic [GAIN_W-1:0] gain
);
  localparam logic [GAIN_W-1:0] CAP_V = GAIN_W'(CAP);

  always_ff @(posedge clk) begin
    if (!rst_n) gain <= '0;
    else if (load) gain <= load_val;
    else if (tick) begin
      if (rise && gain < CAP_V)        gain <= gain + GAIN_W'(1);
      else if (!rise && gain != '0)    gain <= gain - GAIN_W'(1);
    end
  end

  assert_no_climb_past_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && gain <= CAP_V) |=> (gain <= CAP_V));
  assert_no_rise_above_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && gain > CAP_V) |=> (gain <= $past(gain)));
  assert_no_wrap_below_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && gain == '0 && !rise) |=> (gain == '0));
endmodule

// File: rtl/gain_ramp.sv
module gain_ramp
  import gain_ramp_pkg::*;
#(
  parameter int GAIN_W   = GAIN_BITS,
  parameter int RATE_W   = RATE_BITS,
  parameter int PRESCALE = PRE_SCALE,
  parameter int CAP      = GAIN_LIMIT,
  localparam int RD_W    = GAIN_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [RD_W-1:0]   cfg_data,
  input  logic [RATE_W-1:0] glob_rate,
  input  logic              env_halt,
  input  logic              wave_halt,
  output logic [GAIN_W-1:0] gain_raw,
  output logic [GAIN_W-1:0] gain_clamped,
  output logic [RD_W-1:0]   rd_data
);
  localparam logic [GAIN_W-1:0] CAP_V = GAIN_W'(CAP);

  logic              off_q, rise_q;
  logic [GAIN_W-1:0] rate_q;
  logic              run, tick, clr, load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_q  <= 1'b1;
      rise_q <= 1'b0;
      rate_q <= '0;
    end else if (cfg_wr) begin
      off_q  <= cfg_data[RD_W-1];
      rise_q <= cfg_data[RD_W-2];
      rate_q <= cfg_data[GAIN_W-1:0];
    end
  end

  assign run  = !off_q && (glob_rate != '0) && !env_halt && !wave_halt;
  assign clr  = cfg_wr || env_halt;
  assign load = cfg_wr && cfg_data[RD_W-1];

  gain_ramp_timer #(.GAIN_W(GAIN_W), .RATE_W(RATE_W), .PRESCALE(PRESCALE)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(clr), .run(run),
    .glob_rate(glob_rate), .rate_set(rate_q), .tick(tick)
  );

  gain_ramp_level #(.GAIN_W(GAIN_W), .CAP(CAP)) u_level (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(cfg_data[GAIN_W-1:0]),
    .tick(tick), .rise(rise_q), .gain(gain_raw)
  );

  assign gain_clamped = (gain_raw > CAP_V) ? CAP_V : gain_raw;
  assign rd_data      = {2'b01, gain_raw};

  assert_hold_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (off_q && !cfg_wr) |=> $stable(gain_raw));
  assert_hold_when_rate_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (glob_rate == '0 && !cfg_wr) |=> $stable(gain_raw));
  assert_hold_in_env_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (env_halt && !cfg_wr) |=> $stable(gain_raw));
  assert_hold_in_wave_halt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wave_halt && !cfg_wr) |=> $stable(gain_raw));
  assert_keep_gain_on_run_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_data[RD_W-1]) |=> $stable(gain_raw));

  always_comb begin
    if (rst_n) begin
      assert_clamp_limit_R10: assert (gain_clamped <= CAP_V && gain_clamped <= gain_raw);
    end
  end
endmodule

// File: tb/gain_ramp_bench.sv
module gain_ramp_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_data = 8'h00;
  logic [7:0] glob_rate = 8'h01;
  logic       env_halt = 1'b0;
  logic       wave_halt = 1'b0;
  logic [5:0] gain_raw, gain_clamped;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  gain_ramp u_gain_ramp (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
    .glob_rate(glob_rate), .env_halt(env_halt), .wave_halt(wave_halt),
    .gain_raw(gain_raw), .gain_clamped(gain_clamped), .rd_data(rd_data)
  );

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [7:0] b);
    cfg_wr = 1'b1;
    cfg_data = b;
    @(posedge clk);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic until_change(input int limit, output int k);
    logic [5:0] start;
    start = gain_raw;
    k = -1;
    for (int i = 1; i <= limit; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (gain_raw != start) begin
        k = i;
        break;
      end
    end
  endtask

  initial begin
    int k;
    cyc(3);
    // R11 reset state
    check("R11 gain after reset", gain_raw, 0);
    check("R11 readback after reset", rd_data, 8'h40);
    rst_n = 1'b1;
    cyc(200);
    check("R11 no step while off after reset", gain_raw, 0);

    // R1 R10: load every value, clamp and readback
    for (int v = 0; v < 64; v++) begin
      wr(8'h80 | 8'(v));
      check("R1 load value", gain_raw, v);
      check("R10 clamp", gain_clamped, (v > 32) ? 32 : v);
      check("R10 readback", rd_data, 64 + v);
    end

    // R3 R2 R1: period sweep
    for (int g = 1; g <= 3; g++) begin
      for (int si = 0; si < 4; si++) begin
        int s;
        s = (si == 3) ? 5 : si;
        glob_rate = 8'(g);
        wr(8'h80 | 8'd10);
        wr(8'h40 | 8'(s));
        check("R1 run write keeps gain", gain_raw, 10);
        until_change(400, k);
        check("R2 R3 first period after write", k, 8 * g * (s + 1));
        check("R3 upward step", gain_raw, 11);
        until_change(400, k);
        check("R3 steady period", k, 8 * g * (s + 1));
      end
    end

    // R5 upward stops at 32
    glob_rate = 8'd1;
    wr(8'h80 | 8'd30);
    wr(8'h40);
    cyc(100);
    check("R5 climb stops at 32", gain_raw, 32);
    wr(8'h80 | 8'd40);
    wr(8'h40);
    cyc(100);
    check("R5 loaded 40 not raised", gain_raw, 40);
    check("R10 clamp of 40", gain_clamped, 32);

    // R6 downward stops at 0
    wr(8'h80 | 8'd3);
    wr(8'h00);
    cyc(100);
    check("R6 floor at 0", gain_raw, 0);

    // R4 multiplier zero
    wr(8'h80 | 8'd5);
    glob_rate = 8'd0;
    wr(8'h40);
    cyc(150);
    check("R4 no step at rate 0", gain_raw, 5);
    glob_rate = 8'd1;
    until_change(50, k);
    check("R4 steps resume", gain_raw, 6);

    // R7 off flag
    wr(8'h80 | 8'd5);
    cyc(150);
    check("R7 no step while off", gain_raw, 5);

    // R2 rewrite restarts timer (period 32)
    wr(8'h40 | 8'd3);
    cyc(20);
    wr(8'h40 | 8'd3);
    until_change(100, k);
    check("R2 rewrite restarts timer", k, 32);

    // R8 env_halt clears timer
    wr(8'h80 | 8'd5);
    wr(8'h40 | 8'd3);
    cyc(20);
    env_halt = 1'b1;
    cyc(50);
    check("R8 frozen during env halt", gain_raw, 5);
    env_halt = 1'b0;
    until_change(100, k);
    check("R8 full period after release", k, 32);

    // R9 wave_halt holds timer
    wr(8'h80 | 8'd5);
    wr(8'h40 | 8'd3);
    cyc(20);
    wave_halt = 1'b1;
    cyc(50);
    check("R9 frozen during wave halt", gain_raw, 5);
    wave_halt = 1'b0;
    until_change(100, k);
    check("R9 remaining count after release", k, 12);
    check("R9 step value", gain_raw, 6);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule